// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port with Peripheral Overrides

This block runs eight general-purpose pads. Software sets a direction register, an output latch and a small configuration register over a single-cycle register bus. It reads back either the latch or the pad levels. Pad levels pass through a two-flop synchronizer before software can see them. Each pad has three controls: an output value, an output enable and a weak pull-up enable. The pull-up is switched off when a global bit is set or when the pin drives.

Other on-chip functions can take a pin over. A PWM unit can drive pins 0 to 6, and a configuration input can move its channel A onto pin 7. While channel A drives pin 7, that pin can run in open-drain mode. A PWM shutdown event floats every pin the PWM owns. A parallel-port unit can claim pins 0 and 1 for its read and write strobes. When more than one owner wants a pin, the order is fixed: strobe first, then PWM, then plain GPIO.

The register bus carries no stream data, so it has no valid/ready handshake and no back-pressure. A write is taken on the clock edge where `wr_en` is high. A read is combinational on `addr`, with no wait states.

Top module: `gpio8_port`

## Requirements
- R1: On a pin with no override, direction bit 0 sets `pad_oe` high and puts latch bit i on `pad_out`. Direction bit 1 sets `pad_oe` low.
- R2: After reset, every pin is an input: the direction register reads 0xFF and `pad_oe` is 0. The latch reads 0x00. The configuration register reads 0x01, so the pull-ups are off and `pad_pu` is 0.
- R3: Configuration bit 0 is the global pull-up disable. While it is 1, all eight `pad_pu` bits are 0.
- R4: While bit 0 is 0, `pad_pu[i]` is 1 only if the pin is not driving. A pin under GPIO control must also have direction bit 1. So the pull-up is off on every GPIO pin with direction bit 0.
- R5: Configuration bit 1 enables open-drain mode on pin 7. It takes effect only while PWM channel A drives pin 7. In this mode a value of 0 gives `pad_oe`=1 with `pad_out`=0, and a value of 1 gives `pad_oe`=0. At any other time the bit has no effect on the pads.
- R6: When `pwm_own[i]` is 1 (pins 0 to 6), the pin drives `pwm_drv[i]` and its direction bit is ignored. When `pwm_a_on_top` and `pwm_a_own` are both 1, pin 7 drives `pwm_a_drv`. When `pwm_a_on_top` is 0, channel A leaves pin 7 alone.
- R7: While `pwm_shutdown` is 1, every pin owned by the PWM has `pad_oe`=0.
- R8: While `pp_en` is 1, pins 0 and 1 take their output enable and value from `pp_strobe_oe` and `pp_strobe_out`. This ignores both the direction bits and PWM ownership.
- R9: The register map is: address 0 = pad read, address 1 = latch, address 2 = direction, address 3 = configuration (bit 0 pull-up disable, bit 1 open-drain). A write to address 0 or 1 loads the latch on that edge. `rdata` shows the new value one cycle later.
- R10: A level on `pad_in` sampled at clock edge k appears on `rdata` at address 0 just after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad weak pull-up enables |
| pwm_own | input | 7 | PWM claims pins 0..6 |
| pwm_drv | input | 7 | PWM values for pins 0..6 |
| pwm_a_own | input | 1 | PWM channel A active |
| pwm_a_drv | input | 1 | PWM channel A value |
| pwm_a_on_top | input | 1 | Configuration: route channel A to pin 7 |
| pwm_shutdown | input | 1 | PWM shutdown event, floats PWM-owned pins |
| pp_en | input | 1 | Parallel-port strobes own pins 0 and 1 |
| pp_strobe_oe | input | 2 | Strobe output enables for pins 0 and 1 |
| pp_strobe_out | input | 2 | Strobe values for pins 0 and 1 |

## Verification
The pin multiplexer is combinational, so a bad latch, direction or configuration bit shows on `pad_oe`, `pad_out` or `pad_pu` in the cycle after the write that set it. The bench compares all three pad vectors, and the read-back of all four addresses, against a behavioural model on every cycle. It therefore catches the error at the first cycle where the bit matters. A wrong synchronizer depth is different: it shows only as a one-cycle shift in the address-0 read after a pad level changes. The bench therefore toggles `pad_in` every cycle and reads address 0 throughout.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  typedef enum logic [1:0] {
    REG_PADS  = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR   = 2'd2,
    REG_CFG   = 2'd3
  } reg_sel_e;

  localparam int CFG_PU_OFF_BIT = 0;
  localparam int CFG_OD_BIT     = 1;
  localparam int STROBE_PINS    = 2;
  localparam int SYNC_DEPTH     = 2;
endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync
  import gpio8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [SYNC_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_DEPTH; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < SYNC_DEPTH; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[SYNC_DEPTH-1];

  // warm-up counter so the latency check only looks at post-reset samples
  logic [1:0] fill_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == 2'd2) |-> (q == $past(d, 2))); // R10
endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pads_sync,
  output logic [W-1:0] rdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic         pu_off_q,
  output logic         od_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      dir_q    <= '1;
      pu_off_q <= 1'b1;
      od_q     <= 1'b0;
    end else if (wr_en) begin
      unique case (sel)
        REG_PADS, REG_LATCH: latch_q <= wdata;
        REG_DIR:             dir_q   <= wdata;
        REG_CFG: begin
          pu_off_q <= wdata[CFG_PU_OFF_BIT];
          od_q     <= wdata[CFG_OD_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      REG_PADS:  rdata = pads_sync;
      REG_LATCH: rdata = latch_q;
      REG_DIR:   rdata = dir_q;
      REG_CFG: begin
        rdata[CFG_PU_OFF_BIT] = pu_off_q;
        rdata[CFG_OD_BIT]     = od_q;
      end
      default: rdata = '0;
    endcase
  end

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == REG_PADS || addr == REG_LATCH)) |=> (latch_q == $past(wdata))); // R9
endmodule

// File: rtl/gpio8_pin_mux.sv
module gpio8_pin_mux
  import gpio8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   shutdown,
  input  logic [W-1:0]           lat,
  input  logic [W-1:0]           dir,
  input  logic                   pu_off,
  input  logic                   od_en,
  input  logic [W-2:0]           pwm_own,
  input  logic [W-2:0]           pwm_drv,
  input  logic                   pwm_a_own,
  input  logic                   pwm_a_drv,
  input  logic                   pwm_a_on_top,
  input  logic                   pp_en,
  input  logic [STROBE_PINS-1:0] pp_strobe_oe,
  input  logic [STROBE_PINS-1:0] pp_strobe_out,
  output logic [W-1:0]           pad_out,
  output logic [W-1:0]           pad_oe,
  output logic [W-1:0]           pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic strb_sel, strb_oe, strb_val;
    logic pwm_sel, pwm_val, od_mode;
    logic o_out, o_oe, gpio_ctl;

    if (i < STROBE_PINS) begin : g_strb
      assign strb_sel = pp_en;
      assign strb_oe  = pp_strobe_oe[i];
      assign strb_val = pp_strobe_out[i];
    end else begin : g_nostrb
      assign strb_sel = 1'b0;
      assign strb_oe  = 1'b0;
      assign strb_val = 1'b0;
    end

    if (i < W-1) begin : g_pwm_low
      assign pwm_sel = pwm_own[i];
      assign pwm_val = pwm_drv[i];
      assign od_mode = 1'b0;
    end else begin : g_pwm_top
      assign pwm_sel = pwm_a_on_top & pwm_a_own;
      assign pwm_val = pwm_a_drv;
      assign od_mode = od_en;
    end

    always_comb begin
      gpio_ctl = 1'b0;
      if (strb_sel) begin
        o_oe  = strb_oe;
        o_out = strb_val;
      end else if (pwm_sel) begin
        if (shutdown) begin
          o_oe  = 1'b0;
          o_out = 1'b0;
        end else if (od_mode) begin
          o_oe  = ~pwm_val;
          o_out = 1'b0;
        end else begin
          o_oe  = 1'b1;
          o_out = pwm_val;
        end
      end else begin
        gpio_ctl = 1'b1;
        o_oe     = ~dir[i];
        o_out    = lat[i];
      end
    end

    assign pad_out[i] = o_out;
    assign pad_oe[i]  = o_oe;
    assign pad_pu[i]  = ~pu_off & ~o_oe & (~gpio_ctl | dir[i]);
  end
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port
  import gpio8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             addr,
  input  logic [W-1:0]           wdata,
  output logic [W-1:0]           rdata,
  input  logic [W-1:0]           pad_in,
  output logic [W-1:0]           pad_out,
  output logic [W-1:0]           pad_oe,
  output logic [W-1:0]           pad_pu,
  input  logic [W-2:0]           pwm_own,
  input  logic [W-2:0]           pwm_drv,
  input  logic                   pwm_a_own,
  input  logic                   pwm_a_drv,
  input  logic                   pwm_a_on_top,
  input  logic                   pwm_shutdown,
  input  logic                   pp_en,
  input  logic [STROBE_PINS-1:0] pp_strobe_oe,
  input  logic [STROBE_PINS-1:0] pp_strobe_out
);
  localparam int TOP = W - 1;

  logic [W-1:0] pads_sync, latch_q, dir_q;
  logic         pu_off_q, od_q;

  gpio8_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pads_sync)
  );

  gpio8_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pads_sync(pads_sync), .rdata(rdata), .latch_q(latch_q), .dir_q(dir_q),
    .pu_off_q(pu_off_q), .od_q(od_q)
  );

  gpio8_pin_mux #(.W(W)) u_mux (
    .shutdown(pwm_shutdown), .lat(latch_q), .dir(dir_q), .pu_off(pu_off_q),
    .od_en(od_q), .pwm_own(pwm_own), .pwm_drv(pwm_drv), .pwm_a_own(pwm_a_own),
    .pwm_a_drv(pwm_a_drv), .pwm_a_on_top(pwm_a_on_top), .pp_en(pp_en),
    .pp_strobe_oe(pp_strobe_oe), .pp_strobe_out(pp_strobe_out),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  AST_PU_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pu_off_q |-> (pad_pu == '0)); // R3

  AST_SHUTDOWN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_shutdown && !pp_en) |-> ((pad_oe[W-2:0] & pwm_own) == '0)); // R7

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q && pwm_a_on_top && pwm_a_own) |-> !(pad_oe[TOP] && pad_out[TOP])); // R5

  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pp_en |-> (pad_oe[STROBE_PINS-1:0] == pp_strobe_oe)); // R8
endmodule

// File: tb/gpio8_port_tb.sv
module gpio8_port_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, pad_in, pad_out, pad_oe, pad_pu;
  logic [6:0] pwm_own, pwm_drv;
  logic       pwm_a_own, pwm_a_drv, pwm_a_on_top, pwm_shutdown, pp_en;
  logic [1:0] pp_strobe_oe, pp_strobe_out;

  gpio8_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pwm_own(pwm_own), .pwm_drv(pwm_drv),
    .pwm_a_own(pwm_a_own), .pwm_a_drv(pwm_a_drv), .pwm_a_on_top(pwm_a_on_top),
    .pwm_shutdown(pwm_shutdown), .pp_en(pp_en), .pp_strobe_oe(pp_strobe_oe),
    .pp_strobe_out(pp_strobe_out)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R2";

  // behavioural model state
  logic [7:0] m_lat = 8'h00, m_dir = 8'hFF;
  logic       m_pu_off = 1'b1, m_od = 1'b0;
  logic [7:0] m_s1 = 8'h00, m_s2 = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = 8'h00; m_dir = 8'hFF; m_pu_off = 1'b1; m_od = 1'b0;
      m_s1 = 8'h00; m_s2 = 8'h00;
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (wr_en) begin
        if (addr == 2'd0 || addr == 2'd1) m_lat = wdata;
        else if (addr == 2'd2) m_dir = wdata;
        else begin m_pu_off = wdata[0]; m_od = wdata[1]; end
      end
    end
  end

  task automatic expect_pads(output logic [7:0] e_oe, output logic [7:0] e_out,
                             output logic [7:0] e_pu);
    for (int i = 0; i < 8; i++) begin
      bit owned_gpio = 0;
      bit pwm_has;
      bit pwm_bit;
      pwm_has = (i < 7) ? pwm_own[i] : (pwm_a_on_top && pwm_a_own);
      pwm_bit = (i < 7) ? pwm_drv[i] : pwm_a_drv;
      e_out[i] = 1'b0;
      if (pp_en && i < 2) begin
        e_oe[i] = pp_strobe_oe[i]; e_out[i] = pp_strobe_out[i];
      end else if (pwm_has) begin
        if (pwm_shutdown) e_oe[i] = 1'b0;
        else if (i == 7 && m_od) e_oe[i] = !pwm_bit;
        else begin e_oe[i] = 1'b1; e_out[i] = pwm_bit; end
      end else begin
        owned_gpio = 1;
        e_oe[i] = !m_dir[i]; e_out[i] = m_lat[i];
      end
      e_pu[i] = !m_pu_off && !e_oe[i] && (!owned_gpio || m_dir[i]);
    end
  endtask

  task automatic check8(string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_oe, e_out, e_pu, e_rd;
    expect_pads(e_oe, e_out, e_pu);
    case (addr)
      2'd0: e_rd = m_s2;
      2'd1: e_rd = m_lat;
      2'd2: e_rd = m_dir;
      default: e_rd = {6'b0, m_od, m_pu_off};
    endcase
    check8("pad_oe", pad_oe, e_oe);
    check8("pad_out", pad_out & e_oe, e_out & e_oe);
    check8("pad_pu", pad_pu, e_pu);
    check8("rdata", rdata, e_rd);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic write_reg(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic sweep_reads();
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      tick();
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00; pad_in = 8'h00;
    pwm_own = '0; pwm_drv = '0; pwm_a_own = 0; pwm_a_drv = 0; pwm_a_on_top = 0;
    pwm_shutdown = 0; pp_en = 0; pp_strobe_oe = '0; pp_strobe_out = '0;
    repeat (3) @(negedge clk);
    cur_req = "R2";
    sweep_reads();
    addr = 2'd2; @(negedge clk); compare_all();
    check8("dir after reset", rdata, 8'hFF);
    rst_n = 1'b1;
    sweep_reads();

    cur_req = "R9";
    write_reg(2'd1, 8'hA5); addr = 2'd1; tick();
    check8("latch via addr 1", rdata, 8'hA5);
    write_reg(2'd0, 8'h3C); addr = 2'd1; tick();
    check8("latch via addr 0", rdata, 8'h3C);

    cur_req = "R1";
    write_reg(2'd2, 8'h0F); sweep_reads();
    check8("oe from dir", pad_oe, 8'hF0);
    check8("out from latch", pad_out & 8'hF0, 8'h30);

    cur_req = "R4";
    write_reg(2'd3, 8'h00); sweep_reads();
    check8("pu only on inputs", pad_pu, 8'h0F);
    cur_req = "R3";
    write_reg(2'd3, 8'h01); sweep_reads();
    check8("pu global off", pad_pu, 8'h00);
    write_reg(2'd3, 8'h00);

    cur_req = "R10";
    addr = 2'd0;
    for (int k = 0; k < 40; k++) begin pad_in = 8'(k * 37 + 5); tick(); end
    pad_in = 8'h81; tick(); tick();
    check8("pad 2 edges later", rdata, 8'h81);

    cur_req = "R6";
    write_reg(2'd2, 8'hFF);
    pwm_own = 7'h55; pwm_drv = 7'h14; sweep_reads();
    check8("pwm pins drive", pad_oe, 8'h55);
    pwm_a_own = 1; pwm_a_drv = 1; sweep_reads();
    check8("chan A unrouted", pad_oe & 8'h80, 8'h00);
    pwm_a_on_top = 1; sweep_reads();
    check8("chan A on pin 7", pad_oe & pad_out & 8'h80, 8'h80);

    cur_req = "R7";
    pwm_shutdown = 1; sweep_reads();
    check8("shutdown floats", pad_oe, 8'h00);
    pwm_shutdown = 0;

    cur_req = "R5";
    write_reg(2'd3, 8'h02);
    pwm_a_drv = 1; sweep_reads();
    check8("od release", pad_oe & 8'h80, 8'h00);
    pwm_a_drv = 0; sweep_reads();
    check8("od drive low", {pad_oe[7], pad_out[7]} , 8'h02);
    pwm_a_on_top = 0; write_reg(2'd2, 8'h7F); write_reg(2'd1, 8'h80); sweep_reads();
    check8("od ignored on gpio", {pad_oe[7], pad_out[7]}, 8'h03);

    cur_req = "R8";
    pp_en = 1; pp_strobe_oe = 2'b01; pp_strobe_out = 2'b11; sweep_reads();
    check8("strobe pins", pad_oe & 8'h03, 8'h01);

    cur_req = "mix";
    for (int k = 0; k < 3000; k++) begin
      wr_en = ($urandom_range(0, 3) == 0);
      addr = 2'($urandom); wdata = 8'($urandom); pad_in = 8'($urandom);
      pwm_own = 7'($urandom); pwm_drv = 7'($urandom);
      pwm_a_own = 1'($urandom); pwm_a_drv = 1'($urandom);
      pwm_a_on_top = 1'($urandom); pwm_shutdown = ($urandom_range(0, 4) == 0);
      pp_en = 1'($urandom); pp_strobe_oe = 2'($urandom); pp_strobe_out = 2'($urandom);
      tick();
    end
    wr_en = 0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule